// File: doc/BRIEF.md
# Pipelined Fetch-and-Add Unit

This block keeps a small array of data words and performs one fetch-and-add per clock cycle. Each operation names a source entry, a destination entry and an offset. The unit returns the source word plus the offset, and it stores that sum in the destination entry. Operations can be issued back to back with no stall, and a later operation always sees the sums of every earlier one. This holds even when it reads an entry that the previous operation, or the one before that, has just produced.

Operands are accepted two cycles before the matching sum appears, so the array read starts early. The feedback from a sum to the next operand is split over two register stages. Two address comparators decide where each operand comes from. The "far" comparator checks the incoming source address against the sum now being written, and repairs the early array read. The "near" comparator checks the source address against the operation one step ahead. On a match, the sum is rebuilt with a three-input adder from both offsets and the operand the earlier operation used. The array is never read for that operation's value. The sequence of results is the same as if every read, add and write happened one at a time.

Top module: `fetch_add_unit`

## Requirements
- R1: For every issued operation, `out_sum` equals the word then held at `in_raddr` plus `in_offset`. It appears with `out_valid` high two clock edges after the operation is presented.
- R2: The sum of each valid operation is written to entry `in_waddr`. Any later operation that reads that entry, however many cycles later, uses the written value.
- R3: When an operation reads the entry written by the valid operation issued one cycle earlier, it uses that operation's sum.
- R4: When an operation reads the entry written by the valid operation issued two cycles earlier, and the operation in between did not write that entry, it uses the older sum.
- R5: When the valid operations one and two cycles earlier both wrote the entry being read, the operand is the sum of the one-cycle-earlier operation.
- R6: A cycle with `in_valid` low writes nothing and forwards nothing. Two cycles later it gives `out_valid` low and `out_sum` zero.
- R7: A synchronous active-high `rst` clears every array entry and all pipeline state. While reset is held, and until the first result arrives, `out_valid` and `out_sum` are zero. After reset, every entry reads as zero.
- R8: Addition wraps modulo 2^DATA_W.
- R9: One operation is accepted every cycle. `out_valid` equals `in_valid` delayed by exactly two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_raddr | input | ADDR_W | Entry whose value is fetched |
| in_waddr | input | ADDR_W | Entry that receives the sum |
| in_offset | input | DATA_W | Value added to the fetched word |
| out_valid | output | 1 | A result is present on `out_sum` |
| out_sum | output | DATA_W | Fetched word plus offset; zero when no result |

## Verification
The array state shows only through later results. A missed or misdirected write, or a wrong comparator choice, therefore stays hidden until some later operation reads the affected entry. The bench forces such reads quickly by drawing addresses from a very small set, so that most operations depend on the one or two before them. A wrong operand then shows on `out_sum` two edges after the faulty operation is issued. A corrupted entry that nothing reads for a while shows up at the next read of that entry, which the random phase keeps within a few cycles. A reset that leaves the array dirty shows on the first read of each entry after a second reset in the middle of the run.

// File: rtl/fadd_pkg.sv
package fadd_pkg;

  // Where the near-stage operand pair for the three-input adder comes from
  typedef enum logic [0:0] {
    PAIR_STORED = 1'b0,  // early array word (possibly repaired by the far match)
    PAIR_CHAIN  = 1'b1   // previous operation's offset and operand
  } pair_src_e;

endpackage

// File: rtl/fadd_store.sv
module fadd_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] cells [DEPTH];
  logic              rd_in_range;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst) begin
        cells[i] <= '0;
      end else if (wr_en && ({1'b0, wr_addr} == (ADDR_W+1)'(i))) begin
        cells[i] <= wr_data;
      end
    end
  end

  assign rd_in_range = ({1'b0, rd_addr} < (ADDR_W+1)'(DEPTH));

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_in_range && ({1'b0, rd_addr} == (ADDR_W+1)'(i))) begin
        rd_data = cells[i];
      end
    end
  end

endmodule

// File: rtl/fadd_match.sv
module fadd_match #(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              slot_live,
  input  logic [ADDR_W-1:0] slot_addr,
  output logic              hit
);

  // A slot without a live operation never matches
  assign hit = slot_live && (probe_addr == slot_addr);

endmodule

// File: rtl/fadd_sum.sv
module fadd_sum
  import fadd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_raddr,
  input  logic [ADDR_W-1:0] in_waddr,
  input  logic [DATA_W-1:0] in_offset,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              hit_far,
  input  logic              hit_near,
  output logic              b_v,
  output logic [ADDR_W-1:0] b_raddr,
  output logic [DATA_W-1:0] b_off,
  output logic [DATA_W-1:0] b_opnd,
  output logic              c_v,
  output logic [ADDR_W-1:0] c_waddr,
  output logic [DATA_W-1:0] c_sum
);

  function automatic logic [DATA_W-1:0] add3(
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] y,
    input logic [DATA_W-1:0] z
  );
    return x + y + z;
  endfunction

  logic [ADDR_W-1:0] b_waddr;
  logic [DATA_W-1:0] c_off;
  logic [DATA_W-1:0] c_base;

  pair_src_e         pair_sel;
  logic [DATA_W-1:0] far_word;
  logic [DATA_W-1:0] pair_off;
  logic [DATA_W-1:0] pair_base;
  logic [DATA_W-1:0] own_base;
  logic [DATA_W-1:0] next_sum;

  // Early read repaired with the sum being written this cycle
  assign far_word = hit_far ? c_sum : rd_word;

  assign pair_sel = hit_near ? PAIR_CHAIN : PAIR_STORED;

  always_comb begin
    unique case (pair_sel)
      PAIR_CHAIN: begin
        pair_off  = c_off;
        pair_base = c_base;
      end
      default: begin
        pair_off  = '0;
        pair_base = b_opnd;
      end
    endcase
  end

  // Operand this operation effectively used, kept for the next one
  assign own_base = hit_near ? c_sum : b_opnd;
  assign next_sum = add3(b_off, pair_off, pair_base);

  always_ff @(posedge clk) begin
    if (rst) begin
      b_v     <= 1'b0;
      b_raddr <= '0;
      b_waddr <= '0;
      b_off   <= '0;
      b_opnd  <= '0;
      c_v     <= 1'b0;
      c_waddr <= '0;
      c_off   <= '0;
      c_base  <= '0;
      c_sum   <= '0;
    end else begin
      b_v     <= in_valid;
      b_raddr <= in_raddr;
      b_waddr <= in_waddr;
      b_off   <= in_offset;
      b_opnd  <= far_word;
      c_v     <= b_v;
      c_waddr <= b_waddr;
      c_off   <= b_off;
      c_base  <= own_base;
      c_sum   <= b_v ? next_sum : '0;
    end
  end

endmodule

// File: rtl/fetch_add_unit.sv
module fetch_add_unit #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_raddr,
  input  logic [ADDR_W-1:0] in_waddr,
  input  logic [DATA_W-1:0] in_offset,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sum
);

  logic [DATA_W-1:0] rd_word;
  logic              hit_far;
  logic              hit_near;
  logic              b_v;
  logic [ADDR_W-1:0] b_raddr;
  logic [DATA_W-1:0] b_off;
  logic [DATA_W-1:0] b_opnd;
  logic              c_v;
  logic [ADDR_W-1:0] c_waddr;
  logic [DATA_W-1:0] c_sum;

  fadd_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (in_raddr),
    .rd_data (rd_word),
    .wr_en   (c_v),
    .wr_addr (c_waddr),
    .wr_data (c_sum)
  );

  // Incoming operation against the one two steps ahead (being written now)
  fadd_match #(.ADDR_W(ADDR_W)) u_far (
    .probe_addr (in_raddr),
    .slot_live  (c_v),
    .slot_addr  (c_waddr),
    .hit        (hit_far)
  );

  // Operation in the add stage against the one immediately ahead
  fadd_match #(.ADDR_W(ADDR_W)) u_near (
    .probe_addr (b_raddr),
    .slot_live  (c_v),
    .slot_addr  (c_waddr),
    .hit        (hit_near)
  );

  fadd_sum #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sum (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_raddr  (in_raddr),
    .in_waddr  (in_waddr),
    .in_offset (in_offset),
    .rd_word   (rd_word),
    .hit_far   (hit_far),
    .hit_near  (hit_near),
    .b_v       (b_v),
    .b_raddr   (b_raddr),
    .b_off     (b_off),
    .b_opnd    (b_opnd),
    .c_v       (c_v),
    .c_waddr   (c_waddr),
    .c_sum     (c_sum)
  );

  assign out_valid = c_v;
  assign out_sum   = c_sum;

endmodule

// File: rtl/fetch_add_unit_chk.sv
module fetch_add_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_sum,
  input logic              b_v,
  input logic [DATA_W-1:0] b_off,
  input logic [DATA_W-1:0] b_opnd,
  input logic              hit_near,
  input logic              hit_far
);

  logic [1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc <= '0;
    end else if (cyc != 2'd3) begin
      cyc <= cyc + 2'd1;
    end
  end

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_sum == '0));

  assert_hit_live_R6: assert property (@(posedge clk) disable iff (rst)
    (hit_near || hit_far) |-> out_valid);

  assert_near_chain_R3: assert property (@(posedge clk) disable iff (rst)
    (b_v && hit_near) |=> (out_sum == DATA_W'($past(b_off) + $past(out_sum))));

  assert_far_fwd_R4: assert property (@(posedge clk) disable iff (rst)
    hit_far |=> (b_opnd == $past(out_sum)));

  assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (cyc < 2'd2) |-> (!out_valid && out_sum == '0));

endmodule

bind fetch_add_unit fetch_add_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_sum   (out_sum),
  .b_v       (b_v),
  .b_off     (b_off),
  .b_opnd    (b_opnd),
  .hit_near  (hit_near),
  .hit_far   (hit_far)
);

// File: tb/sim_fetch_add_unit.sv
module sim_fetch_add_unit;
  localparam int W  = 16;
  localparam int D  = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_raddr = '0;
  logic [AW-1:0] in_waddr = '0;
  logic [W-1:0]  in_offset = '0;
  logic          out_valid;
  logic [W-1:0]  out_sum;

  always #4 clk = ~clk;

  fetch_add_unit #(.DATA_W(W), .DEPTH(D)) u0 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_raddr  (in_raddr),
    .in_waddr  (in_waddr),
    .in_offset (in_offset),
    .out_valid (out_valid),
    .out_sum   (out_sum)
  );

  typedef struct {
    bit           v;
    logic [W-1:0] s;
    string        tag;
  } exp_t;

  int      checks = 0;
  int      errors = 0;
  bit      done = 0;
  exp_t    expq[$];
  logic [W-1:0] shadow [D];
  bit      written [D];
  bit      h1_v, h2_v;
  logic [AW-1:0] h1_wa, h2_wa;
  string   phase_tag = "";

  task automatic check_out();
    if (expq.size() == 2) begin
      exp_t e;
      e = expq.pop_front();
      checks++;
      if (out_valid !== e.v) begin
        errors++;
        $display("FAIL R9: out_valid=%0b expected %0b", out_valid, e.v);
      end else if (out_sum !== e.s) begin
        errors++;
        $display("FAIL %s: out_sum=%h expected %h", e.tag, out_sum, e.s);
      end
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < D; i++) begin
      shadow[i]  = '0;
      written[i] = 1'b0;
    end
    h1_v = 1'b0; h2_v = 1'b0; h1_wa = '0; h2_wa = '0;
    expq.delete();
  endtask

  task automatic step(input bit v, input logic [AW-1:0] ra,
                      input logic [AW-1:0] wa, input logic [W-1:0] off);
    exp_t e;
    bit d1, d2;
    logic [W:0] full;
    @(negedge clk);
    check_out();
    in_valid = v; in_raddr = ra; in_waddr = wa; in_offset = off;
    if (v) begin
      d1   = h1_v && (h1_wa == ra);
      d2   = h2_v && (h2_wa == ra);
      full = {1'b0, shadow[ra]} + {1'b0, off};
      e.v  = 1'b1;
      e.s  = full[W-1:0];
      if (phase_tag != "")  e.tag = phase_tag;
      else if (full[W])     e.tag = "R8";
      else if (d1 && d2)    e.tag = "R5";
      else if (d1)          e.tag = "R3";
      else if (d2)          e.tag = "R4";
      else if (written[ra]) e.tag = "R2";
      else                  e.tag = "R1";
      shadow[wa]  = e.s;
      written[wa] = 1'b1;
    end else begin
      e.v = 1'b0; e.s = '0; e.tag = "R6";
    end
    h2_v = h1_v; h2_wa = h1_wa;
    h1_v = v;    h1_wa = wa;
    expq.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    clear_model();
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_sum !== '0) begin
        errors++;
        $display("FAIL R7: valid=%0b sum=%h expected 0/0000", out_valid, out_sum);
      end
    end
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: fresh entries read as zero plus offset
    for (int a = 0; a < D; a++) step(1'b1, AW'(a), AW'(a), W'(a * 3 + 1));
    // R2: read back entries written long ago
    for (int a = 0; a < D; a++) step(1'b1, AW'(a), AW'(a), W'(100 + a));
    // R3: back-to-back chain on one entry
    for (int k = 0; k < 6; k++) step(1'b1, 4'd5, 4'd5, W'(7 + k));
    // R4: two interleaved chains
    for (int k = 0; k < 8; k++) begin
      if (k % 2 == 0) step(1'b1, 4'd6, 4'd6, W'(3 + k));
      else            step(1'b1, 4'd9, 4'd9, W'(11 + k));
    end
    // R4 across a bubble
    step(1'b1, 4'd7, 4'd7, 16'h0010);
    step(1'b0, 4'd7, 4'd7, 16'h5555);
    step(1'b1, 4'd7, 4'd7, 16'h0001);
    // R5: two writers of the same entry, then a reader
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 4'd0, 4'd12, W'(20 + k));
      step(1'b1, 4'd1, 4'd12, W'(40 + k));
      step(1'b1, 4'd12, 4'd13, W'(1));
    end
    // R6: idle cycles carrying addresses must not write or forward
    step(1'b1, 4'd8, 4'd8, 16'h0004);
    step(1'b0, 4'd8, 4'd8, 16'h0900);
    step(1'b0, 4'd3, 4'd8, 16'h0900);
    step(1'b1, 4'd8, 4'd8, 16'h0002);
    step(1'b0, 4'd8, 4'd8, 16'h0777);
    step(1'b1, 4'd2, 4'd3, 16'h0001);
    step(1'b1, 4'd8, 4'd11, 16'h0000);
    // R8: wrap-around
    step(1'b1, 4'd10, 4'd10, 16'hFFF0);
    step(1'b1, 4'd10, 4'd10, 16'h0020);
    step(1'b1, 4'd14, 4'd14, 16'hFFFF);
    step(1'b1, 4'd15, 4'd14, 16'hFFFF);
    step(1'b1, 4'd14, 4'd14, 16'hFFFF);
    // Random phase with dense collisions
    for (int n = 0; n < 4000; n++) begin
      bit v;
      logic [AW-1:0] ra, wa;
      v  = ($urandom % 8) != 0;
      ra = (($urandom % 4) == 0) ? AW'($urandom % D) : AW'($urandom % 4);
      wa = (($urandom % 4) == 0) ? AW'($urandom % D) : AW'($urandom % 4);
      step(v, ra, wa, W'($urandom));
    end
    // R7: second reset must clear every entry
    do_reset();
    phase_tag = "R7";
    for (int a = 0; a < D; a++) step(1'b1, AW'(a), AW'(a), W'(a + 1000));
    phase_tag = "";
    for (int k = 0; k < 3; k++) step(1'b0, '0, '0, '0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule